// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Layer

This block is the addressing stage of a single-wire bus slave. It sits between a physical-layer timing engine and the device's memory-function logic. After the bus master issues a bus reset, the block collects an 8-bit selection command, least significant bit first. It then runs one of seven selection flows against the device's 64-bit identity word:

- read the identity back,
- compare it bit by bit,
- take part in a tree search,
- skip addressing,
- resume a previous selection,
- skip addressing or match the identity while switching the bus to high speed.

When a flow selects the device, the block raises `grant`. That hands the bus to the memory layer until the next bus reset.

The physical layer reports three kinds of event, each as a one-cycle strobe:

- a written bit,
- a request for a bit to send in a read slot,
- a bus reset, flagged as long (regular-speed) or short.

The block drives the line in open-drain fashion. It pulls low only to send a 0. It keeps two persistent flags:

- a resume flag, set only by a completed compare or search flow,
- a high-speed flag, set by the two high-speed flows and cleared by a long bus reset.

A serial CRC-8 checker walks the identity word once after chip reset and reports whether its check byte is consistent.

Top module: `rom_cmd_layer`

## Requirements
- R1: Command bits are taken only after a bus reset. Eight `rx_valid` strobes form one command, with the first bit as bit 0. Any later bus reset discards a partly received command. Command codes: 33h identity read, 55h identity compare, F0h search, CCh skip, A5h resume, 3Ch high-speed skip, 69h high-speed compare.
- R2: Identity read (33h) clears the resume flag. It then answers 64 `tx_req` strobes with identity bits 0 through 63 in order: family byte (bits 7:0) first, then the 48-bit serial, then the check byte (bits 63:56). After the 64th bit it raises `grant`.
- R3: Identity compare (55h) checks each received bit against the identity bit of the same index, starting at bit 0. A mismatch clears the resume flag and makes the block ignore the bus until a bus reset. Matching all 64 bits sets the resume flag and raises `grant`.
- R4: Search (F0h) handles each identity bit in three steps, starting at bit 0:
  - on one `tx_req` it sends the bit itself;
  - on the next `tx_req` it sends the bit's complement;
  - it then receives the master's chosen bit.

  A chosen bit that differs from the identity bit clears the resume flag and drops the block out. Completing all 64 bits sets the resume flag and raises `grant`.
- R5: Skip (CCh) clears the resume flag and raises `grant` at once. High-speed skip (3Ch) does the same and also sets `od_mode`.
- R6: High-speed compare (69h) sets `od_mode` as soon as the command is decoded, whatever the outcome. It then behaves as R3.
- R7: Resume (A5h) raises `grant` only when the resume flag is 1. Otherwise the block ignores the bus until a bus reset. Resume leaves the flag unchanged.
- R8: A bus reset drops `grant` and restarts command reception. A long reset clears `od_mode`; a short one leaves it unchanged. The resume flag is kept across bus resets.
- R9: An unknown command code, or an idle state after a dropout, ignores `rx_valid` and `tx_req` with the line released until the next bus reset. While `grant` is high it is held until a bus reset.
- R10: `tx_pull_low` is high only while `tx_req` is high in a transmit step and the bit to send is 0. A 1 bit is sent by leaving the line released.
- R11: After chip reset, the CRC checker shifts the 64 identity bits LSB first into an 8-bit register. The register starts at zero and uses polynomial x^8+x^5+x^4+1. `crc_done` rises within 65 cycles and then stays high. `crc_ok` is 1 exactly when the register ends at zero.
- R12: Synchronous `rst` clears `grant`, `od_mode` and the resume flag. Afterwards the block ignores the bus until the first bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high chip reset |
| rom_id | input | ID_BITS | Identity word: family byte low, serial, check byte high |
| bus_reset | input | 1 | Strobe: bus reset detected by the physical layer |
| reset_long | input | 1 | Qualifies `bus_reset`: 1 for a regular-speed (long) reset |
| rx_valid | input | 1 | Strobe: a written bit has been sampled |
| rx_bit | input | 1 | Value of the written bit |
| tx_req | input | 1 | Strobe: a read slot needs a bit from this block |
| tx_pull_low | output | 1 | Open-drain drive: 1 pulls the line low during `tx_req` |
| grant | output | 1 | Memory-function layer owns the bus |
| od_mode | output | 1 | High-speed mode flag |
| rc_flag | output | 1 | Resume flag |
| crc_done | output | 1 | Identity check-byte walk finished |
| crc_ok | output | 1 | Identity check byte consistent |

## Verification
The bench builds the block with its default 64-bit identity and 8-bit command width. At these values the identity word has its real layout, so one word with a valid check byte and one with a corrupted check byte exercise both outcomes of the CRC checker. Random identities and random mismatch positions from 0 to 63 move compare and search dropouts across every byte of the word, including the first and the last bit. A random mix of commands and long or short bus resets checks how the resume and high-speed flags carry from one selection to the next.

// File: rtl/rom_cmd_pkg.sv
package rom_cmd_pkg;

    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] OP_READ_ID   = 8'h33;
    localparam logic [CMD_W-1:0] OP_MATCH_ID  = 8'h55;
    localparam logic [CMD_W-1:0] OP_SEARCH    = 8'hF0;
    localparam logic [CMD_W-1:0] OP_SKIP      = 8'hCC;
    localparam logic [CMD_W-1:0] OP_RESUME    = 8'hA5;
    localparam logic [CMD_W-1:0] OP_FAST_SKIP = 8'h3C;
    localparam logic [CMD_W-1:0] OP_FAST_MTCH = 8'h69;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SRCH_TRUE,
        ST_SRCH_CMPL,
        ST_SRCH_PICK,
        ST_GRANT
    } rom_state_e;

    typedef struct packed {
        rom_state_e next;
        logic       rc_clr;
        logic       od_set;
    } cmd_action_t;

    // One LSB-first step of the reflected x^8+x^5+x^4+1 register.
    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return {1'b0, c[7:1]} ^ (fb ? 8'h8C : 8'h00);
    endfunction

    function automatic cmd_action_t decode_cmd(input logic [CMD_W-1:0] op,
                                               input logic rc);
        cmd_action_t a;
        a = '{next: ST_IDLE, rc_clr: 1'b0, od_set: 1'b0};
        case (op)
            OP_READ_ID:   begin a.next = ST_READ;  a.rc_clr = 1'b1; end
            OP_MATCH_ID:  a.next = ST_MATCH;
            OP_SEARCH:    a.next = ST_SRCH_TRUE;
            OP_SKIP:      begin a.next = ST_GRANT; a.rc_clr = 1'b1; end
            OP_FAST_SKIP: begin a.next = ST_GRANT; a.rc_clr = 1'b1; a.od_set = 1'b1; end
            OP_FAST_MTCH: begin a.next = ST_MATCH; a.od_set = 1'b1; end
            OP_RESUME:    a.next = rc ? ST_GRANT : ST_IDLE;
            default:      a.next = ST_IDLE;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/rom_cmd_deser.sv
module rom_cmd_deser
    import rom_cmd_pkg::*;
#(
    parameter int WIDTH = CMD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic             cmd_valid,
    output logic [WIDTH-1:0] cmd_out
);
    localparam int CNT_W = $clog2(WIDTH);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    logic [WIDTH-1:0] shreg;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (shift_en) begin
            shreg <= {bit_in, shreg[WIDTH-1:1]};
            cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign cmd_out   = {bit_in, shreg[WIDTH-1:1]};
    assign cmd_valid = shift_en && !clear && (cnt == LAST);
endmodule

// File: rtl/rom_id_cursor.sv
module rom_id_cursor #(
    parameter int ID_BITS = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               step,
    input  logic [ID_BITS-1:0] id,
    output logic               own_bit,
    output logic               last
);
    localparam int IDX_W = $clog2(ID_BITS);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_BITS - 1);

    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst || clear)
            idx <= '0;
        else if (step && idx != IDX_LAST)
            idx <= idx + 1'b1;
    end

    assign own_bit = id[idx];
    assign last    = (idx == IDX_LAST);
endmodule

// File: rtl/rom_crc8_chk.sv
module rom_crc8_chk
    import rom_cmd_pkg::*;
#(
    parameter int ID_BITS = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ID_BITS-1:0] id,
    output logic               done,
    output logic               ok
);
    localparam int IDX_W = $clog2(ID_BITS);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_BITS - 1);

    logic [7:0]       crc;
    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc  <= '0;
            idx  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            crc <= crc8_step(crc, id[idx]);
            if (idx == IDX_LAST)
                done <= 1'b1;
            else
                idx <= idx + 1'b1;
        end
    end

    assign ok = done && (crc == 8'h00);
endmodule

// File: rtl/rom_cmd_layer.sv
module rom_cmd_layer
    import rom_cmd_pkg::*;
#(
    parameter int ID_BITS = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ID_BITS-1:0] rom_id,
    input  logic               bus_reset,
    input  logic               reset_long,
    input  logic               rx_valid,
    input  logic               rx_bit,
    input  logic               tx_req,
    output logic               tx_pull_low,
    output logic               grant,
    output logic               od_mode,
    output logic               rc_flag,
    output logic               crc_done,
    output logic               crc_ok
);
    rom_state_e        state;
    logic              cmd_valid;
    logic [CMD_W-1:0]  cmd_byte;
    logic              own_bit;
    logic              id_last;
    logic              cur_step;
    logic              bit_match;
    cmd_action_t       act;

    rom_cmd_deser #(.WIDTH(CMD_W)) u_deser (
        .clk       (clk),
        .rst       (rst),
        .clear     (bus_reset),
        .shift_en  (rx_valid && state == ST_CMD),
        .bit_in    (rx_bit),
        .cmd_valid (cmd_valid),
        .cmd_out   (cmd_byte)
    );

    rom_id_cursor #(.ID_BITS(ID_BITS)) u_cursor (
        .clk     (clk),
        .rst     (rst),
        .clear   (bus_reset),
        .step    (cur_step),
        .id      (rom_id),
        .own_bit (own_bit),
        .last    (id_last)
    );

    rom_crc8_chk #(.ID_BITS(ID_BITS)) u_crc (
        .clk  (clk),
        .rst  (rst),
        .id   (rom_id),
        .done (crc_done),
        .ok   (crc_ok)
    );

    assign bit_match = (rx_bit == own_bit);
    assign act       = decode_cmd(cmd_byte, rc_flag);

    always_comb begin
        cur_step = 1'b0;
        case (state)
            ST_READ:               cur_step = tx_req;
            ST_MATCH, ST_SRCH_PICK: cur_step = rx_valid && bit_match;
            default:               cur_step = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            rc_flag <= 1'b0;
            od_mode <= 1'b0;
        end else if (bus_reset) begin
            state <= ST_CMD;
            if (reset_long)
                od_mode <= 1'b0;
        end else begin
            case (state)
                ST_CMD: if (cmd_valid) begin
                    state <= act.next;
                    if (act.rc_clr) rc_flag <= 1'b0;
                    if (act.od_set) od_mode <= 1'b1;
                end
                ST_READ: if (tx_req && id_last)
                    state <= ST_GRANT;
                ST_MATCH: if (rx_valid) begin
                    if (!bit_match) begin
                        rc_flag <= 1'b0;
                        state   <= ST_IDLE;
                    end else if (id_last) begin
                        rc_flag <= 1'b1;
                        state   <= ST_GRANT;
                    end
                end
                ST_SRCH_TRUE: if (tx_req) state <= ST_SRCH_CMPL;
                ST_SRCH_CMPL: if (tx_req) state <= ST_SRCH_PICK;
                ST_SRCH_PICK: if (rx_valid) begin
                    if (!bit_match) begin
                        rc_flag <= 1'b0;
                        state   <= ST_IDLE;
                    end else if (id_last) begin
                        rc_flag <= 1'b1;
                        state   <= ST_GRANT;
                    end else begin
                        state <= ST_SRCH_TRUE;
                    end
                end
                default: state <= state;
            endcase
        end
    end

    always_comb begin
        tx_pull_low = 1'b0;
        if (tx_req) begin
            case (state)
                ST_READ, ST_SRCH_TRUE: tx_pull_low = !own_bit;
                ST_SRCH_CMPL:          tx_pull_low = own_bit;
                default:               tx_pull_low = 1'b0;
            endcase
        end
    end

    assign grant = (state == ST_GRANT);
endmodule

// File: rtl/rom_cmd_layer_chk.sv
module rom_cmd_layer_chk (
    input logic clk,
    input logic rst,
    input logic bus_reset,
    input logic reset_long,
    input logic tx_req,
    input logic tx_pull_low,
    input logic grant,
    input logic od_mode,
    input logic rc_flag,
    input logic crc_done
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!grant && !od_mode && !rc_flag)); // R12

    AST_GRANT_DROP: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> !grant); // R8

    AST_LONG_RESET_OD: assert property (@(posedge clk) disable iff (rst)
        (bus_reset && reset_long) |=> !od_mode); // R8

    AST_SHORT_RESET_OD: assert property (@(posedge clk) disable iff (rst)
        (bus_reset && !reset_long && od_mode) |=> od_mode); // R8

    AST_RC_KEPT_ON_RESET: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (rc_flag == $past(rc_flag))); // R8

    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (rst)
        (grant && !bus_reset) |=> grant); // R9

    AST_LINE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !tx_req |-> !tx_pull_low); // R10

    AST_CRC_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        crc_done |=> crc_done); // R11
endmodule

bind rom_cmd_layer rom_cmd_layer_chk u_rom_cmd_layer_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_reset   (bus_reset),
    .reset_long  (reset_long),
    .tx_req      (tx_req),
    .tx_pull_low (tx_pull_low),
    .grant       (grant),
    .od_mode     (od_mode),
    .rc_flag     (rc_flag),
    .crc_done    (crc_done)
);

// File: tb/tb_rom_cmd_layer.sv
module tb_rom_cmd_layer;
    localparam int CLK_PERIOD = 10;
    localparam int IDB = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [IDB-1:0] rom_id = '0;
    logic bus_reset = 1'b0, reset_long = 1'b0;
    logic rx_valid = 1'b0, rx_bit = 1'b0, tx_req = 1'b0;
    logic tx_pull_low, grant, od_mode, rc_flag, crc_done, crc_ok;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic exp_rc, exp_od;

    always #(CLK_PERIOD/2) clk = ~clk;

    rom_cmd_layer #(.ID_BITS(IDB)) dut (
        .clk(clk), .rst(rst), .rom_id(rom_id), .bus_reset(bus_reset),
        .reset_long(reset_long), .rx_valid(rx_valid), .rx_bit(rx_bit),
        .tx_req(tx_req), .tx_pull_low(tx_pull_low), .grant(grant),
        .od_mode(od_mode), .rc_flag(rc_flag), .crc_done(crc_done), .crc_ok(crc_ok)
    );

    function automatic logic [7:0] ref_crc(input logic [55:0] d);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            logic mix = c[0] ^ d[i];
            c = c >> 1;
            if (mix) c = c ^ 8'h8C;
        end
        return c;
    endfunction

    function automatic logic [63:0] make_id(input logic [55:0] body);
        return {ref_crc(body), body};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); rx_bit = b; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic read_bit(output logic v);
        @(negedge clk); tx_req = 1'b1;
        #1 v = !tx_pull_low;
        @(negedge clk); tx_req = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] c);
        for (int i = 0; i < 8; i++) send_bit(c[i]);
    endtask

    task automatic bus_rst(input logic long_pulse);
        @(negedge clk); bus_reset = 1'b1; reset_long = long_pulse;
        @(negedge clk); bus_reset = 1'b0; reset_long = 1'b0;
        if (long_pulse) exp_od = 1'b0;
    endtask

    task automatic check_flags(input string req, input logic g);
        check({req, " grant"}, 64'(grant), 64'(g));
        check({req, " rc"}, 64'(rc_flag), 64'(exp_rc));
        check({req, " od"}, 64'(od_mode), 64'(exp_od));
    endtask

    // Line stays released and nothing changes while the block ignores the bus.
    task automatic check_quiet(input string req);
        logic v;
        read_bit(v);
        check({req, " line released"}, 64'(v), 64'd1);
        send_bit(1'b0);
        send_bit(1'b1);
        check({req, " no grant"}, 64'(grant), 64'd0);
    endtask

    task automatic do_read(input string req);
        logic [63:0] got;
        send_cmd(8'h33);
        exp_rc = 1'b0;
        check({req, " rc cleared"}, 64'(rc_flag), 64'd0);
        for (int i = 0; i < 64; i++) begin
            logic v;
            read_bit(v);
            got[i] = v;
        end
        check({req, " id bits"}, got, rom_id);
        check_flags(req, 1'b1);
    endtask

    task automatic do_match(input string req, input logic [7:0] op, input int flip);
        send_cmd(op);
        if (op == 8'h69) begin
            exp_od = 1'b1;
            check({req, " od early"}, 64'(od_mode), 64'd1);
        end
        for (int i = 0; i < 64; i++) send_bit(i == flip ? !rom_id[i] : rom_id[i]);
        exp_rc = (flip < 0);
        check_flags(req, flip < 0);
    endtask

    task automatic do_search(input string req, input int div);
        send_cmd(8'hF0);
        for (int i = 0; i < 64; i++) begin
            logic t, c;
            read_bit(t);
            read_bit(c);
            check({req, " true bit"}, 64'(t), 64'(rom_id[i]));
            check({req, " complement"}, 64'(c), 64'(!rom_id[i]));
            send_bit(i == div ? !rom_id[i] : rom_id[i]);
            if (i == div) break;
        end
        exp_rc = (div < 0);
        check_flags(req, div < 0);
    endtask

    initial begin
        logic [63:0] good_id;
        process::self().srandom(32'h5EED_0A11);
        exp_rc = 1'b0;
        exp_od = 1'b0;
        good_id = make_id({$urandom, $urandom} & 56'hFF_FFFF_FFFF_FFFF);
        rom_id = good_id;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R12 reset state grant", 64'(grant), 64'd0);
        check("R12 reset state od", 64'(od_mode), 64'd0);
        check("R12 reset state rc", 64'(rc_flag), 64'd0);
        repeat (66) @(negedge clk);
        check("R11 crc done", 64'(crc_done), 64'd1);
        check("R11 crc ok on valid id", 64'(crc_ok), 64'd1);

        // R1 / R12: no command accepted before the first bus reset
        send_cmd(8'hCC);
        check("R1 skip before bus reset ignored", 64'(grant), 64'd0);

        bus_rst(1'b1); do_read("R2 read id");
        bus_rst(1'b1); do_match("R3 match ok", 8'h55, -1);
        begin
            logic v;
            read_bit(v);
            check("R10 released during grant", 64'(v), 64'd1);
        end
        bus_rst(1'b1);
        check("R8 grant dropped by reset", 64'(grant), 64'd0);
        check("R8 rc kept across reset", 64'(rc_flag), 64'd1);
        send_cmd(8'hA5);
        check_flags("R7 resume with rc", 1'b1);
        bus_rst(1'b1); send_cmd(8'hCC); exp_rc = 1'b0;
        check_flags("R5 skip", 1'b1);
        bus_rst(1'b1); send_cmd(8'hA5);
        check_flags("R7 resume without rc", 1'b0);
        check_quiet("R7 resume refused");

        bus_rst(1'b1); do_match("R3 match ok again", 8'h55, -1);
        bus_rst(1'b1); do_match("R3 match miss bit0", 8'h55, 0);
        check_quiet("R9 after match miss");
        bus_rst(1'b1); do_match("R3 match miss bit63", 8'h55, 63);
        bus_rst(1'b1); do_search("R4 search full", -1);
        bus_rst(1'b1); do_search("R4 search diverge", int'($urandom_range(0, 63)));
        check_quiet("R4 after dropout");

        bus_rst(1'b1); send_cmd(8'h3C); exp_rc = 1'b0; exp_od = 1'b1;
        check_flags("R5 fast skip", 1'b1);
        bus_rst(1'b0);
        check("R8 short reset keeps od", 64'(od_mode), 64'd1);
        bus_rst(1'b1);
        check("R8 long reset clears od", 64'(od_mode), 64'd0);
        bus_rst(1'b1); do_match("R6 fast match miss", 8'h69, int'($urandom_range(0, 63)));
        bus_rst(1'b1); do_match("R6 fast match ok", 8'h69, -1);

        bus_rst(1'b1); send_cmd(8'h00);
        check_flags("R9 unknown code", 1'b0);
        check_quiet("R9 unknown code idle");

        // R1: partial command discarded by a bus reset
        bus_rst(1'b1);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        bus_rst(1'b1); send_cmd(8'hCC); exp_rc = 1'b0;
        check_flags("R1 partial command discarded", 1'b1);

        // Random mix of commands and reset lengths
        for (int it = 0; it < 40; it++) begin
            int op = int'($urandom_range(0, 7));
            int bad = ($urandom_range(0, 1) == 0) ? -1 : int'($urandom_range(0, 63));
            bus_rst(logic'($urandom_range(0, 1)));
            case (op)
                0: do_read("R2 random read");
                1: do_match("R3 random match", 8'h55, bad);
                2: do_search("R4 random search", bad);
                3: begin send_cmd(8'hCC); exp_rc = 1'b0; check_flags("R5 random skip", 1'b1); end
                4: begin send_cmd(8'h3C); exp_rc = 1'b0; exp_od = 1'b1;
                         check_flags("R5 random fast skip", 1'b1); end
                5: do_match("R6 random fast match", 8'h69, bad);
                6: begin send_cmd(8'hA5); check_flags("R7 random resume", exp_rc); end
                default: begin send_cmd(8'h5A); check_flags("R9 random unknown", 1'b0); end
            endcase
        end

        // R11 / R12: corrupted check byte, chip reset while in high speed
        bus_rst(1'b1); send_cmd(8'h3C);
        @(negedge clk); rst = 1'b1;
        rom_id = good_id ^ 64'h0100_0000_0000_0000;
        @(negedge clk); rst = 1'b0;
        #1;
        check("R12 rst clears od", 64'(od_mode), 64'd0);
        check("R12 rst clears grant", 64'(grant), 64'd0);
        repeat (66) @(negedge clk);
        check("R11 crc done bad id", 64'(crc_done), 64'd1);
        check("R11 crc flags bad id", 64'(crc_ok), 64'd0);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule